// File: doc/BRIEF.md
# Selectable-Timebase 16-bit Event Counter

This block is a free-running up-counter. It advances by one on each pulse from a timebase that a small mode register selects. The timebase can be one of the following:

- the system clock undivided
- the system clock divided by four or by twelve
- the overflow strobe of a neighbouring timer
- falling edges on an external count pin
- an external oscillator divided by eight

The pin and the external oscillator are both brought safely into the system clock domain before they act as count enables.

When the counter wraps from all-ones to zero, a sticky overflow flag is set. Software clears the flag with a write. An enable bit in the mode register gates the flag onto an interrupt request. Another mode bit freezes the counter while the CPU reports idle. The two reserved select codes stop all counting.

Top module: `timebase_counter`

## Requirements
- R1: After reset the count is 0, the mode readback is 0x00 (select code 000), the overflow flag is 0 and the interrupt request is 0.
- R2: With select code 000 (mode bits 3..1), the count advances exactly once in every 12 system clock cycles.
- R3: With select code 001, the count advances exactly once in every 4 system clock cycles.
- R4: With select code 010, the count advances once for each system clock cycle in which the timer-overflow input is high.
- R5: With select code 011, the count advances once per high-to-low transition of the count pin, when each level is held for at least 2 cycles. The increment becomes visible on the third rising clock edge after the pin falls.
- R6: With select code 100, the count advances on every system clock cycle.
- R7: With select code 101, the count advances once per 8 rising edges of the external clock.
- R8: Select codes 110 and 111 stop the count completely.
- R9: When mode bit 7 is 1 and the idle input is high, the count holds. When mode bit 7 is 0, the idle input has no effect.
- R10: A wrap from 0xFFFF to 0x0000 sets the overflow flag, and the flag stays set. A write to address 1 with data bit 7 equal to 0 clears it. A write with data bit 7 equal to 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R11: The interrupt request is high exactly when the overflow flag is set and mode bit 0 is 1.
- R12: A write to address 0 loads mode bit 7, bits 3..1 and bit 0. Bits 6..4 always read back as 0. A mode write does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External oscillator clock |
| tmr_ovf_i | input | 1 | Neighbouring timer overflow strobe (system domain) |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| cpu_idle_i | input | 1 | CPU idle indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = mode register, 1 = overflow flag clear |
| wr_data_i | input | 8 | Write data |
| count_o | output | 16 | Current count |
| mode_o | output | 8 | Mode register readback |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Masked overflow interrupt request |

## Verification
The counter is driven in turn from each of the six live timebases, and each run is scored over a fixed window.

- The divide-by-12 and divide-by-4 windows show that the two prescaler ratios are not swapped.
- The strobe run uses sparse pulses, and the pin run uses slow square waves. Together they separate level-counting from edge-counting.
- The external clock runs on a period that is not commensurate with the system clock. This exercises the crossing.

Reserved codes and idle suspension are applied with the counter otherwise free to run, so that any leak shows up as movement. Two full wraps test the sticky flag: one with the interrupt mask toggled, and one timed so that a clearing write lands on the very wrap cycle.

// File: rtl/tbsel_pkg.sv
package tbsel_pkg;

    typedef enum logic [2:0] {
        SRC_DIV_SLOW = 3'b000,
        SRC_DIV_FAST = 3'b001,
        SRC_TMR_OVF  = 3'b010,
        SRC_PIN_FALL = 3'b011,
        SRC_SYSCLK   = 3'b100,
        SRC_EXT_DIV  = 3'b101,
        SRC_RSVD_A   = 3'b110,
        SRC_RSVD_B   = 3'b111
    } src_sel_e;

    typedef struct packed {
        logic     idle_hold;
        src_sel_e sel;
        logic     ovf_ie;
    } mode_t;

    localparam int MODE_HOLD_BIT = 7;
    localparam int MODE_SEL_LSB  = 1;
    localparam int MODE_SEL_MSB  = 3;
    localparam int MODE_IE_BIT   = 0;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;

endpackage

// File: rtl/tbsel_sysdiv.sv
module tbsel_sysdiv #(
    parameter int DIV = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic pulse_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        pulse_o = (cnt_q == LAST);
        cnt_d   = pulse_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tbsel_extdiv.sv
module tbsel_extdiv #(
    parameter int DIV_LOG2 = 3
) (
    input  logic ext_clk_i,
    input  logic rst_ni,
    output logic slow_o
);
    logic [DIV_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q + 1'b1;
        slow_o = cnt_q[DIV_LOG2-1];
    end

    always_ff @(posedge ext_clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tbsel_sync_edge.sv
module tbsel_sync_edge #(
    parameter int STAGES    = 2,
    parameter bit FALL_EDGE = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic pulse_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [TOP:0] chain;
        logic         prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[TOP-1:0], async_i};
        st_d.prev  = st_q.chain[TOP];
    end

    generate
        if (FALL_EDGE) begin : g_fall
            assign pulse_o = st_q.prev & ~st_q.chain[TOP];
        end else begin : g_rise
            assign pulse_o = ~st_q.prev & st_q.chain[TOP];
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/tbsel_src_mux.sv
module tbsel_src_mux
    import tbsel_pkg::*;
(
    input  src_sel_e sel_i,
    input  logic     slow_i,
    input  logic     fast_i,
    input  logic     tovf_i,
    input  logic     pin_i,
    input  logic     ext_i,
    output logic     tick_o
);
    always_comb begin
        unique case (sel_i)
            SRC_DIV_SLOW: tick_o = slow_i;
            SRC_DIV_FAST: tick_o = fast_i;
            SRC_TMR_OVF:  tick_o = tovf_i;
            SRC_PIN_FALL: tick_o = pin_i;
            SRC_SYSCLK:   tick_o = 1'b1;
            SRC_EXT_DIV:  tick_o = ext_i;
            default:      tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
    import tbsel_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int SLOW_DIV     = 12,
    parameter int FAST_DIV     = 4,
    parameter int EXT_DIV_LOG2 = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ext_clk_i,
    input  logic             tmr_ovf_i,
    input  logic             cnt_pin_i,
    input  logic             cpu_idle_i,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [7:0]       wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic [7:0]       mode_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);
    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] count;
        logic             flag;
    } core_t;

    core_t core_d, core_q;

    logic slow_p, fast_p, pin_p, ext_slow, ext_p, tick;
    logic hold, adv, wrap, clr_req;

    tbsel_sysdiv #(.DIV(SLOW_DIV)) u_div_slow (
        .clk_i(clk_i), .rst_ni(rst_ni), .pulse_o(slow_p)
    );

    tbsel_sysdiv #(.DIV(FAST_DIV)) u_div_fast (
        .clk_i(clk_i), .rst_ni(rst_ni), .pulse_o(fast_p)
    );

    tbsel_sync_edge #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_pin_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cnt_pin_i), .pulse_o(pin_p)
    );

    tbsel_extdiv #(.DIV_LOG2(EXT_DIV_LOG2)) u_ext_div (
        .ext_clk_i(ext_clk_i), .rst_ni(rst_ni), .slow_o(ext_slow)
    );

    tbsel_sync_edge #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_ext_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ext_slow), .pulse_o(ext_p)
    );

    tbsel_src_mux u_mux (
        .sel_i (core_q.mode.sel),
        .slow_i(slow_p),
        .fast_i(fast_p),
        .tovf_i(tmr_ovf_i),
        .pin_i (pin_p),
        .ext_i (ext_p),
        .tick_o(tick)
    );

    always_comb begin
        core_d  = core_q;
        hold    = core_q.mode.idle_hold & cpu_idle_i;
        adv     = tick & ~hold;
        wrap    = adv & (core_q.count == '1);
        clr_req = wr_en_i & (wr_addr_i == ADDR_FLAG) & ~wr_data_i[7];

        if (adv) core_d.count = core_q.count + 1'b1;

        if (wrap)         core_d.flag = 1'b1;
        else if (clr_req) core_d.flag = 1'b0;

        if (wr_en_i && (wr_addr_i == ADDR_MODE)) begin
            core_d.mode.idle_hold = wr_data_i[MODE_HOLD_BIT];
            core_d.mode.sel       = src_sel_e'(wr_data_i[MODE_SEL_MSB:MODE_SEL_LSB]);
            core_d.mode.ovf_ie    = wr_data_i[MODE_IE_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    assign count_o    = core_q.count;
    assign mode_o     = {core_q.mode.idle_hold, 3'b000, core_q.mode.sel, core_q.mode.ovf_ie};
    assign ovf_flag_o = core_q.flag;
    assign irq_o      = core_q.flag & core_q.mode.ovf_ie;

endmodule

// File: rtl/tbsel_chk.sv
module tbsel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cpu_idle_i,
    input logic [CNT_W-1:0] count_o,
    input logic [7:0]       mode_o,
    input logic             ovf_flag_o,
    input logic             irq_o
);
    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(count_o) |-> count_o == $past(count_o) + 1'b1);

    // R6
    sysclk_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o[3:1] == 3'b100 && !(mode_o[7] && cpu_idle_i)) |=> count_o == $past(count_o) + 1'b1);

    // R8
    reserved_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o[3:1] == 3'b110 || mode_o[3:1] == 3'b111) |=> $stable(count_o));

    // R9
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o[7] && cpu_idle_i) |=> $stable(count_o));

    // R10
    flag_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_flag_o) |-> count_o == '0);

    // R11
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ovf_flag_o && mode_o[0]));
endmodule

bind timebase_counter tbsel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_idle_i(cpu_idle_i),
    .count_o   (count_o),
    .mode_o    (mode_o),
    .ovf_flag_o(ovf_flag_o),
    .irq_o     (irq_o)
);

// File: tb/timebase_counter_test.sv
`timescale 1ns/100ps
module timebase_counter_test;
    logic clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0;
    logic tovf = 1'b0, pin = 1'b1, idle = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [15:0] count;
    logic [7:0] mode;
    logic flag, irq;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";

    timebase_counter uut (
        .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .tmr_ovf_i(tovf),
        .cnt_pin_i(pin), .cpu_idle_i(idle), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .count_o(count), .mode_o(mode), .ovf_flag_o(flag), .irq_o(irq)
    );

    initial forever #2.5 clk = ~clk;
    initial begin
        #1.2;
        forever begin ext_clk = 1'b1; #3.3; ext_clk = 1'b0; #3.3; end
    end

    // ---------------- behavioural reference model ----------------
    int m_ext;
    always @(posedge ext_clk or negedge rst_n)
        if (!rst_n) m_ext = 0; else m_ext = (m_ext + 1) % 8;

    int m_p12, m_p4, m_sel, m_count;
    bit m_hold, m_ie, m_flag;
    bit m_pin[$], m_tog[$];

    always @(posedge clk or negedge rst_n) begin
        bit tk, adv;
        if (!rst_n) begin
            m_p12 = 0; m_p4 = 0; m_sel = 0; m_count = 0;
            m_hold = 0; m_ie = 0; m_flag = 0;
            m_pin = '{0, 0, 0}; m_tog = '{0, 0, 0};
        end else begin
            case (m_sel)
                0: tk = (m_p12 == 11);
                1: tk = (m_p4 == 3);
                2: tk = tovf;
                3: tk = m_pin[2] && !m_pin[1];
                4: tk = 1;
                5: tk = m_tog[1] && !m_tog[2];
                default: tk = 0;
            endcase
            adv = tk && !(m_hold && idle);
            if (adv && m_count == 65535) m_flag = 1;
            else if (wr_en && wr_addr && !wr_data[7]) m_flag = 0;
            if (adv) m_count = (m_count + 1) % 65536;
            if (wr_en && !wr_addr) begin
                m_hold = wr_data[7]; m_sel = wr_data[3:1]; m_ie = wr_data[0];
            end
            m_p12 = (m_p12 + 1) % 12;
            m_p4  = (m_p4 + 1) % 4;
            void'(m_pin.pop_back()); m_pin.push_front(pin);
            void'(m_tog.pop_back()); m_tog.push_front(m_ext >= 4);
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " count"}, count, m_count);
            chk({cur_req, " flag"}, flag, m_flag);
            chk({cur_req, " irq"}, irq, m_flag && m_ie);
            chk({cur_req, " mode"}, mode, {m_hold, 3'b000, 3'(m_sel), m_ie});
        end
    end

    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic delta(int n, output int d);
        int c0 = count;
        repeat (n) @(negedge clk);
        d = (count - c0) & 16'hFFFF;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        int d, c0, lim;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 mode", mode, 0);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);

        cur_req = "R2"; delta(48, d); chk("R2 div12 window", d, 4);

        cur_req = "R3"; wr(0, 8'h02); delta(40, d); chk("R3 div4 window", d, 10);

        cur_req = "R4"; wr(0, 8'h04);
        c0 = count;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk) tovf = 1;
            @(negedge clk) tovf = 0;
            repeat (2) @(negedge clk);
        end
        chk("R4 strobe count", (count - c0) & 16'hFFFF, 7);

        cur_req = "R5"; wr(0, 8'h06); repeat (4) @(negedge clk);
        c0 = count;
        pin = 0;
        repeat (2) @(negedge clk);
        chk("R5 before third edge", count, c0);
        @(negedge clk);
        chk("R5 on third edge", count, (c0 + 1) & 16'hFFFF);
        pin = 1; repeat (3) @(negedge clk);
        c0 = count;
        for (int i = 0; i < 5; i++) begin
            pin = 0; repeat (3) @(negedge clk);
            pin = 1; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R5 five falls", (count - c0) & 16'hFFFF, 5);

        cur_req = "R6"; wr(0, 8'h08); delta(20, d); chk("R6 every cycle", d, 20);

        cur_req = "R7"; wr(0, 8'h0A); delta(400, d);
        chk("R7 ext/8 window", (d >= 36 && d <= 39), 1);

        cur_req = "R8"; wr(0, 8'h0C); delta(30, d); chk("R8 code 110", d, 0);
        wr(0, 8'h0E); delta(30, d); chk("R8 code 111", d, 0);

        cur_req = "R12"; c0 = count; wr(0, 8'hF8);
        chk("R12 readback", mode, 8'h88);
        chk("R12 count untouched", count, c0);

        cur_req = "R9"; idle = 1; delta(20, d); chk("R9 hold on idle", d, 0);
        idle = 0; delta(20, d); chk("R9 runs when awake", d, 20);
        wr(0, 8'h08); idle = 1; delta(20, d); chk("R9 idle ignored", d, 20);
        idle = 0;

        cur_req = "R10"; wr(0, 8'h09);
        lim = 0;
        while (!m_flag && lim < 70000) begin @(negedge clk); lim++; end
        chk("R10 flag after wrap", flag, 1);
        chk("R10 count wrapped small", count < 4, 1);
        cur_req = "R11"; chk("R11 irq enabled", irq, 1);
        wr(0, 8'h08); chk("R11 irq masked", irq, 0); chk("R11 flag kept", flag, 1);
        cur_req = "R10"; wr(1, 8'h80); chk("R10 bit7 set keeps flag", flag, 1);
        wr(1, 8'h00); chk("R10 cleared", flag, 0);
        lim = 0;
        while (m_count != 65535 && lim < 70000) begin @(negedge clk); lim++; end
        wr_en = 1; wr_addr = 1; wr_data = 8'h00;
        @(negedge clk); wr_en = 0;
        chk("R10 wrap beats clear", flag, 1);
        chk("R10 count at zero", count, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule